// File: doc/BRIEF.md
# Multithreaded Fetch PC Sequencer

This block holds fetch state for several hardware threads. For each thread it keeps a program counter, a PC-valid flag, a running sequence-number counter and a record of which pipeline stage it has blocked. When the fetch side grants a thread, the block issues that thread's PC and next sequence number, then steps the PC by one 4-byte instruction. A thread whose PC is not valid gets a stall indication and no fetch.

Control instructions reported by a later stage are handled in one of three ways. A return with no predicted target invalidates the thread's PC and blocks the reporting stage. A predicted-taken branch produces a squash request whose boundary keeps the delay-slot instruction. A predicted not-taken branch is ignored. Squash requests come back on several parallel ports. Within one cycle the block accepts, for each thread, the oldest of the requests. It then redirects the PC, marks it valid and unblocks the stage that was recorded. Activate and deactivate inputs start and stop threads.

All outputs are registered and change one clock after the inputs that cause them.

Top module: `fetch_pc_seq`

## Requirements
- R1: While rst_n is low, and in the cycle after it rises, every output pulse is 0. After reset every thread is valid, has PC equal to its start_pc slice, and has sequence counter 0.
- R2: A fetch_req for a valid thread makes fetch_vld=1 one cycle later. In that cycle fetch_addr is the thread's PC, fetch_seq is its counter and fo_tid is the thread. The PC then steps by 4 and the counter by 1, for that thread only.
- R3: A fetch_req for a thread whose PC is not valid gives fetch_stall=1 and fetch_vld=0 one cycle later. The thread's PC and counter are left unchanged.
- R4: A control report with ctl_ret=1 and ctl_taken=0 clears the thread's valid flag and records ctl_stage for that thread. One cycle later it pulses blk_vld with blk_tid and blk_stage.
- R5: A control report with ctl_taken=1 pulses sreq_vld one cycle later, with sreq_tid, sreq_stage and sreq_bnd = ctl_seq+1. The thread's PC is not changed.
- R6: A control report with ctl_ret=0 and ctl_taken=0 produces no pulse and leaves the PC unchanged.
- R7: Among the squash ports, port 0 has the lowest index. For each thread, the lowest-index valid squash port in a cycle is accepted. A later port for the same thread is accepted only if its sq_bnd is strictly smaller than the boundary accepted so far; equal or larger boundaries are dropped. Different threads are independent.
- R8: An accepted squash with sq_ctl=1 sets the PC to sq_tgt. If the thread's counter is greater than sq_bnd, the PC is set to sq_tgt+4 instead.
- R9: An accepted squash with sq_ctl=0 sets the PC to sq_pc+4.
- R10: An accepted squash sets the thread's valid flag. One cycle later it pulses unblk_vld[thread], with unblk_stage[thread] equal to the recorded block stage.
- R11: deact_vld clears the thread's valid flag and resets its block-stage record to 0.
- R12: act_vld loads the thread's PC from its start_pc slice and sets its valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous reset, active low |
| start_pc | input | NTHR*AW | start address per thread |
| fetch_req | input | 1 | fetch grant |
| fetch_tid | input | TW | granted thread |
| fetch_vld | output | 1 | fetch issued |
| fetch_stall | output | 1 | granted thread had no valid PC |
| fo_tid | output | TW | thread of last grant |
| fetch_addr | output | AW | fetch address |
| fetch_seq | output | SW | assigned sequence number |
| ctl_vld | input | 1 | control instruction report |
| ctl_tid | input | TW | its thread |
| ctl_stage | input | STW | reporting stage |
| ctl_ret | input | 1 | instruction is a return |
| ctl_taken | input | 1 | predicted taken |
| ctl_seq | input | SW | its sequence number |
| blk_vld | output | 1 | block pulse |
| blk_tid | output | TW | blocked thread |
| blk_stage | output | STW | stage to block |
| sreq_vld | output | 1 | squash request pulse |
| sreq_tid | output | TW | thread to squash |
| sreq_stage | output | STW | stage issuing the squash |
| sreq_bnd | output | SW | squash boundary |
| sq_vld | input | NSQ | squash valid per port |
| sq_tid | input | NSQ*TW | squash thread per port |
| sq_bnd | input | NSQ*SW | squash boundary per port |
| sq_ctl | input | NSQ | squash caused by control instruction |
| sq_tgt | input | NSQ*AW | predicted target |
| sq_pc | input | NSQ*AW | PC of squashing instruction |
| unblk_vld | output | NTHR | unblock pulse per thread |
| unblk_stage | output | NTHR*STW | stage to unblock per thread |
| act_vld | input | 1 | activate thread |
| act_tid | input | TW | thread to activate |
| deact_vld | input | 1 | deactivate thread |
| deact_tid | input | TW | thread to deactivate |

## Verification
The assertions check the per-cycle responses on every cycle:
- a grant yields either a fetch or a stall, never both, chosen by the thread's valid flag;
- a return with no predicted target yields a block pulse carrying its stage;
- a taken report yields a squash request whose boundary is its sequence number plus one;
- a not-taken non-return report stays quiet;
- an unblock pulse never appears without a squash in the cycle before.

The bench scenarios cover the remaining behaviour: PC and counter arithmetic across threads, the delay-slot adjustment of a control redirect, oldest-wins filtering between squash ports, and the block-stage record as it is set by a return and then cleared by deactivation.

// File: rtl/fps_pkg.sv
package fps_pkg;
    localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/fps_sq_filter.sv
module fps_sq_filter #(
    parameter int NTHR = 4,
    parameter int TW   = 2,
    parameter int SW   = 16,
    parameter int NSQ  = 2
) (
    input  logic [NSQ-1:0]         sq_vld,
    input  logic [NSQ-1:0][TW-1:0] sq_tid,
    input  logic [NSQ-1:0][SW-1:0] sq_bnd,
    output logic [NSQ-1:0]         acc
);
    logic [NTHR-1:0]         hit;
    logic [NTHR-1:0][SW-1:0] best;

    // lower port first; a later port must be strictly older to win
    always_comb begin
        hit  = '0;
        best = '0;
        acc  = '0;
        for (int p = 0; p < NSQ; p++) begin
            if (sq_vld[p]) begin
                if (!hit[sq_tid[p]] || (sq_bnd[p] < best[sq_tid[p]])) begin
                    acc[p]            = 1'b1;
                    hit[sq_tid[p]]    = 1'b1;
                    best[sq_tid[p]]   = sq_bnd[p];
                end
            end
        end
    end
endmodule

// File: rtl/fps_redirect.sv
module fps_redirect #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic          is_ctl,
    input  logic [AW-1:0] tgt,
    input  logic [AW-1:0] pc,
    input  logic [SW-1:0] bnd,
    input  logic [SW-1:0] cnt,
    output logic [AW-1:0] npc
);
    localparam logic [AW-1:0] STEP = AW'(fps_pkg::INSN_BYTES);

    always_comb begin
        if (is_ctl) begin
            // delay slot already handed out: skip past it
            npc = (cnt > bnd) ? (tgt + STEP) : tgt;
        end else begin
            npc = pc + STEP;
        end
    end
endmodule

// File: rtl/fetch_pc_seq.sv
module fetch_pc_seq #(
    parameter int NTHR = 4,
    parameter int TW   = (NTHR > 1) ? $clog2(NTHR) : 1,
    parameter int AW   = 32,
    parameter int SW   = 16,
    parameter int NSTG = 8,
    parameter int STW  = (NSTG > 1) ? $clog2(NSTG) : 1,
    parameter int NSQ  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NTHR-1:0][AW-1:0]   start_pc,
    input  logic                      fetch_req,
    input  logic [TW-1:0]             fetch_tid,
    output logic                      fetch_vld,
    output logic                      fetch_stall,
    output logic [TW-1:0]             fo_tid,
    output logic [AW-1:0]             fetch_addr,
    output logic [SW-1:0]             fetch_seq,
    input  logic                      ctl_vld,
    input  logic [TW-1:0]             ctl_tid,
    input  logic [STW-1:0]            ctl_stage,
    input  logic                      ctl_ret,
    input  logic                      ctl_taken,
    input  logic [SW-1:0]             ctl_seq,
    output logic                      blk_vld,
    output logic [TW-1:0]             blk_tid,
    output logic [STW-1:0]            blk_stage,
    output logic                      sreq_vld,
    output logic [TW-1:0]             sreq_tid,
    output logic [STW-1:0]            sreq_stage,
    output logic [SW-1:0]             sreq_bnd,
    input  logic [NSQ-1:0]            sq_vld,
    input  logic [NSQ-1:0][TW-1:0]    sq_tid,
    input  logic [NSQ-1:0][SW-1:0]    sq_bnd,
    input  logic [NSQ-1:0]            sq_ctl,
    input  logic [NSQ-1:0][AW-1:0]    sq_tgt,
    input  logic [NSQ-1:0][AW-1:0]    sq_pc,
    output logic [NTHR-1:0]           unblk_vld,
    output logic [NTHR-1:0][STW-1:0]  unblk_stage,
    input  logic                      act_vld,
    input  logic [TW-1:0]             act_tid,
    input  logic                      deact_vld,
    input  logic [TW-1:0]             deact_tid
);
    localparam logic [AW-1:0] STEP = AW'(fps_pkg::INSN_BYTES);

    typedef struct packed {
        logic [NTHR-1:0][AW-1:0]  pc;
        logic [NTHR-1:0]          vld;
        logic [NTHR-1:0][SW-1:0]  seq;
        logic [NTHR-1:0][STW-1:0] bstg;
        logic                     f_vld;
        logic                     f_stall;
        logic [TW-1:0]            f_tid;
        logic [AW-1:0]            f_addr;
        logic [SW-1:0]            f_seq;
        logic                     b_vld;
        logic [TW-1:0]            b_tid;
        logic [STW-1:0]           b_stg;
        logic                     r_vld;
        logic [TW-1:0]            r_tid;
        logic [STW-1:0]           r_stg;
        logic [SW-1:0]            r_bnd;
        logic [NTHR-1:0]          u_vld;
        logic [NTHR-1:0][STW-1:0] u_stg;
    } st_t;

    st_t st_d, st_q;

    logic [NSQ-1:0]          sq_acc;
    logic [NSQ-1:0][AW-1:0]  sq_npc;
    logic [NSQ-1:0][SW-1:0]  sq_cnt;

    fps_sq_filter #(.NTHR(NTHR), .TW(TW), .SW(SW), .NSQ(NSQ)) u_filt (
        .sq_vld (sq_vld),
        .sq_tid (sq_tid),
        .sq_bnd (sq_bnd),
        .acc    (sq_acc)
    );

    for (genvar p = 0; p < NSQ; p++) begin : g_redir
        assign sq_cnt[p] = st_q.seq[sq_tid[p]];
        fps_redirect #(.AW(AW), .SW(SW)) u_redir (
            .is_ctl (sq_ctl[p]),
            .tgt    (sq_tgt[p]),
            .pc     (sq_pc[p]),
            .bnd    (sq_bnd[p]),
            .cnt    (sq_cnt[p]),
            .npc    (sq_npc[p])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.f_vld   = 1'b0;
        st_d.f_stall = 1'b0;
        st_d.b_vld   = 1'b0;
        st_d.r_vld   = 1'b0;
        st_d.u_vld   = '0;

        // fetch grant
        if (fetch_req) begin
            st_d.f_tid = fetch_tid;
            if (st_q.vld[fetch_tid]) begin
                st_d.f_vld          = 1'b1;
                st_d.f_addr         = st_q.pc[fetch_tid];
                st_d.f_seq          = st_q.seq[fetch_tid];
                st_d.pc[fetch_tid]  = st_q.pc[fetch_tid] + STEP;
                st_d.seq[fetch_tid] = st_q.seq[fetch_tid] + 1'b1;
            end else begin
                st_d.f_stall = 1'b1;
            end
        end

        // control instruction report
        if (ctl_vld) begin
            if (ctl_taken) begin
                st_d.r_vld = 1'b1;
                st_d.r_tid = ctl_tid;
                st_d.r_stg = ctl_stage;
                st_d.r_bnd = ctl_seq + 1'b1;
            end else if (ctl_ret) begin
                st_d.vld[ctl_tid]  = 1'b0;
                st_d.bstg[ctl_tid] = ctl_stage;
                st_d.b_vld         = 1'b1;
                st_d.b_tid         = ctl_tid;
                st_d.b_stg         = ctl_stage;
            end
        end

        // accepted squashes, in port order
        for (int p = 0; p < NSQ; p++) begin
            if (sq_acc[p]) begin
                st_d.pc[sq_tid[p]]    = sq_npc[p];
                st_d.vld[sq_tid[p]]   = 1'b1;
                st_d.u_vld[sq_tid[p]] = 1'b1;
                st_d.u_stg[sq_tid[p]] = st_q.bstg[sq_tid[p]];
            end
        end

        if (act_vld) begin
            st_d.pc[act_tid]  = start_pc[act_tid];
            st_d.vld[act_tid] = 1'b1;
        end

        if (deact_vld) begin
            st_d.vld[deact_tid]  = 1'b0;
            st_d.bstg[deact_tid] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pc  <= start_pc;
            st_q.vld <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_vld   = st_q.f_vld;
    assign fetch_stall = st_q.f_stall;
    assign fo_tid      = st_q.f_tid;
    assign fetch_addr  = st_q.f_addr;
    assign fetch_seq   = st_q.f_seq;
    assign blk_vld     = st_q.b_vld;
    assign blk_tid     = st_q.b_tid;
    assign blk_stage   = st_q.b_stg;
    assign sreq_vld    = st_q.r_vld;
    assign sreq_tid    = st_q.r_tid;
    assign sreq_stage  = st_q.r_stg;
    assign sreq_bnd    = st_q.r_bnd;
    assign unblk_vld   = st_q.u_vld;
    assign unblk_stage = st_q.u_stg;

    AST_FETCH_OR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_vld && fetch_stall)); // R3
    AST_GRANT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && st_q.vld[fetch_tid] |=> fetch_vld); // R2
    AST_INVALID_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !st_q.vld[fetch_tid] |=> fetch_stall && !fetch_vld); // R3
    AST_RET_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_vld && ctl_ret && !ctl_taken |=> blk_vld && (blk_stage == $past(ctl_stage))); // R4
    AST_TAKEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_vld && ctl_taken |=> sreq_vld && (sreq_bnd == SW'($past(ctl_seq) + 1'b1))); // R5
    AST_NT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_vld && !ctl_ret && !ctl_taken |=> !sreq_vld && !blk_vld); // R6
    AST_UNBLK_AFTER_SQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|unblk_vld) |-> $past(|sq_vld)); // R10
endmodule

// File: tb/tb_fetch_pc_seq.sv
module tb_fetch_pc_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NTHR = 4, TW = 2, AW = 32, SW = 16, STW = 3, NSQ = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic [NTHR-1:0][AW-1:0] start_pc;
    logic fetch_req; logic [TW-1:0] fetch_tid;
    logic fetch_vld, fetch_stall; logic [TW-1:0] fo_tid;
    logic [AW-1:0] fetch_addr; logic [SW-1:0] fetch_seq;
    logic ctl_vld; logic [TW-1:0] ctl_tid; logic [STW-1:0] ctl_stage;
    logic ctl_ret, ctl_taken; logic [SW-1:0] ctl_seq;
    logic blk_vld; logic [TW-1:0] blk_tid; logic [STW-1:0] blk_stage;
    logic sreq_vld; logic [TW-1:0] sreq_tid; logic [STW-1:0] sreq_stage; logic [SW-1:0] sreq_bnd;
    logic [NSQ-1:0] sq_vld; logic [NSQ-1:0][TW-1:0] sq_tid; logic [NSQ-1:0][SW-1:0] sq_bnd;
    logic [NSQ-1:0] sq_ctl; logic [NSQ-1:0][AW-1:0] sq_tgt, sq_pc;
    logic [NTHR-1:0] unblk_vld; logic [NTHR-1:0][STW-1:0] unblk_stage;
    logic act_vld; logic [TW-1:0] act_tid; logic deact_vld; logic [TW-1:0] deact_tid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_pc_seq #(.NTHR(NTHR), .AW(AW), .SW(SW), .NSTG(8), .NSQ(NSQ)) dut (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        fetch_req = 0; fetch_tid = '0;
        ctl_vld = 0; ctl_tid = '0; ctl_stage = '0; ctl_ret = 0; ctl_taken = 0; ctl_seq = '0;
        sq_vld = '0; sq_tid = '0; sq_bnd = '0; sq_ctl = '0; sq_tgt = '0; sq_pc = '0;
        act_vld = 0; act_tid = '0; deact_vld = 0; deact_tid = '0;
    endtask

    task automatic fetch(int t, bit ok, logic [AW-1:0] ea, logic [SW-1:0] es, string req);
        fetch_req = 1; fetch_tid = TW'(t);
        @(negedge clk); idle();
        chk({req, " fetch_vld"}, 64'(fetch_vld), 64'(ok));
        chk({req, " fetch_stall"}, 64'(fetch_stall), 64'(!ok));
        if (ok) begin
            chk({req, " fetch_addr"}, 64'(fetch_addr), 64'(ea));
            chk({req, " fetch_seq"}, 64'(fetch_seq), 64'(es));
            chk({req, " fo_tid"}, 64'(fo_tid), 64'(t));
        end
    endtask

    task automatic ctl(int t, int stg, bit ret, bit tk, int sq);
        ctl_vld = 1; ctl_tid = TW'(t); ctl_stage = STW'(stg);
        ctl_ret = ret; ctl_taken = tk; ctl_seq = SW'(sq);
        @(negedge clk); idle();
    endtask

    task automatic squash1(int t, int bnd, bit c, logic [AW-1:0] tgt, logic [AW-1:0] pc);
        sq_vld[0] = 1; sq_tid[0] = TW'(t); sq_bnd[0] = SW'(bnd);
        sq_ctl[0] = c; sq_tgt[0] = tgt; sq_pc[0] = pc;
        @(negedge clk); idle();
    endtask

    task automatic squash2(int t0, int b0, logic [AW-1:0] p0, int t1, int b1, logic [AW-1:0] p1);
        sq_vld = 2'b11;
        sq_tid[0] = TW'(t0); sq_bnd[0] = SW'(b0); sq_pc[0] = p0;
        sq_tid[1] = TW'(t1); sq_bnd[1] = SW'(b1); sq_pc[1] = p1;
        @(negedge clk); idle();
    endtask

    task automatic t_reset();
        chk("R1 fetch_vld", 64'(fetch_vld), 0);
        chk("R1 stall", 64'(fetch_stall), 0);
        chk("R1 blk", 64'(blk_vld), 0);
        chk("R1 sreq", 64'(sreq_vld), 0);
        chk("R1 unblk", 64'(unblk_vld), 0);
        for (int t = 0; t < NTHR; t++) fetch(t, 1, start_pc[t], 0, "R1");
    endtask

    task automatic t_fetch();
        fetch(0, 1, 32'h1004, 1, "R2");
        fetch(0, 1, 32'h1008, 2, "R2");
        fetch(0, 1, 32'h100C, 3, "R2");
        fetch(1, 1, 32'h2004, 1, "R2");
    endtask

    task automatic t_return_block();
        ctl(1, 3, 1, 0, 9);
        chk("R4 blk_vld", 64'(blk_vld), 1);
        chk("R4 blk_tid", 64'(blk_tid), 1);
        chk("R4 blk_stage", 64'(blk_stage), 3);
        chk("R4 no sreq", 64'(sreq_vld), 0);
        fetch(1, 0, '0, '0, "R3");
    endtask

    task automatic t_squash_other();
        squash1(1, 1, 0, 32'hDEAD0000, 32'h2000);
        chk("R10 unblk_vld", 64'(unblk_vld), 64'b0010);
        chk("R10 unblk_stage", 64'(unblk_stage[1]), 3);
        fetch(1, 1, 32'h2004, 2, "R9");
    endtask

    task automatic t_taken();
        ctl(0, 2, 0, 1, 3);
        chk("R5 sreq_vld", 64'(sreq_vld), 1);
        chk("R5 sreq_tid", 64'(sreq_tid), 0);
        chk("R5 sreq_stage", 64'(sreq_stage), 2);
        chk("R5 sreq_bnd", 64'(sreq_bnd), 4);
        fetch(0, 1, 32'h1010, 4, "R5");
    endtask

    task automatic t_not_taken();
        ctl(0, 4, 0, 0, 4);
        chk("R6 sreq", 64'(sreq_vld), 0);
        chk("R6 blk", 64'(blk_vld), 0);
        fetch(0, 1, 32'h1014, 5, "R6");
    endtask

    task automatic t_squash_ctl();
        squash1(0, 6, 1, 32'h6000, 32'h0);
        chk("R10 unblk t0", 64'(unblk_vld), 64'b0001);
        chk("R10 unblk stage t0", 64'(unblk_stage[0]), 0);
        fetch(0, 1, 32'h6000, 6, "R8 slot not fetched");
        squash1(0, 6, 1, 32'h7000, 32'h0);
        fetch(0, 1, 32'h7004, 7, "R8 slot fetched");
    endtask

    task automatic t_filter();
        squash2(2, 10, 32'h3000, 2, 12, 32'h3100);
        fetch(2, 1, 32'h3004, 1, "R7 younger dropped");
        squash2(2, 12, 32'h3100, 2, 10, 32'h3200);
        fetch(2, 1, 32'h3204, 2, "R7 older wins");
        squash2(2, 7, 32'h3500, 2, 7, 32'h3600);
        fetch(2, 1, 32'h3504, 3, "R7 equal dropped");
        squash2(2, 20, 32'h3300, 3, 30, 32'h3400);
        chk("R7 both threads unblk", 64'(unblk_vld), 64'b1100);
        fetch(2, 1, 32'h3304, 4, "R7 thread2");
        fetch(3, 1, 32'h3404, 1, "R7 thread3");
    endtask

    task automatic t_deact_act();
        ctl(1, 5, 1, 0, 0);
        chk("R4 blk_stage 5", 64'(blk_stage), 5);
        deact_vld = 1; deact_tid = 2'd1;
        @(negedge clk); idle();
        fetch(1, 0, '0, '0, "R11 invalid");
        act_vld = 1; act_tid = 2'd1;
        @(negedge clk); idle();
        fetch(1, 1, 32'h2000, 3, "R12");
        squash1(1, 2, 0, 32'h0, 32'h2100);
        chk("R11 unblk t1", 64'(unblk_vld), 64'b0010);
        chk("R11 record cleared", 64'(unblk_stage[1]), 0);
        fetch(1, 1, 32'h2104, 4, "R11 after squash");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int t = 0; t < NTHR; t++) start_pc[t] = AW'(32'h1000 * (t + 1));
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R1 in reset blk", 64'(blk_vld), 0);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fetch();
        t_return_block();
        t_squash_other();
        t_taken();
        t_not_taken();
        t_squash_ctl();
        t_filter();
        t_deact_act();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule